// File: doc/BRIEF.md
# Flash Read Buffer With Instruction and Data Read-Ahead

This block sits between a core and a 32-bit non-volatile array. It keeps up to six recently fetched words, each with a valid bit and a word-address tag. A request whose word is held returns after one clock edge. A miss reads the array for one or two cycles, depending on a latency bit, and the word it fetches is then stored. Two enables can start speculative array reads while the array is idle. The instruction enable fetches the word after the latest instruction request. The data enable does the same for the latest data request. A bypass bit turns the buffer off, so every access then has the same fixed timing.

Requests use a valid/ready handshake. A request transfers on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low while a miss is being fetched and while an unconsumed response is waiting. A response holds `rsp_valid` high and `rsp_rdata` stable until the edge where `rsp_ready` is high. The array port is plain. `arr_en` stays high for every cycle of an access, `arr_addr` is held during the access, and `arr_rdata` must be valid for the address driven.

Top module: `flash_rdbuf`

## Requirements
- R1: With the bypass bit low, a request whose word address is held in a valid entry has `rsp_valid` high after exactly one clock edge, counting the accepting edge, and returns the stored word.
- R2: A request that misses has `rsp_valid` high after 2 + L edges, where L is the latency bit, and returns the array word for that address. The response stays valid and stable until it is taken.
- R3: Setting the latency bit adds exactly one cycle to every array access.
- R4: With both read-ahead enables low and the bypass bit low, six distinct words fetched on misses all hit afterwards.
- R5: With the instruction read-ahead enable high, an instruction request (`req_data`=0) to word A fetches A+1 while the array is idle, so a later request to A+1 hits. Data requests start no instruction read-ahead.
- R6: With the data read-ahead enable high, a data request (`req_data`=1) to word A fetches A+1 in the same way. Instruction requests start no data read-ahead.
- R7: With both enables high, entries 0-2 hold instruction fills and entries 3-5 hold data fills, so instruction fills never evict data words. With at most one enable high, both streams share all six entries.
- R8: When its partition is full, a fill replaces that partition's least recently used entry. Both a hit and a fill count as a use.
- R9: With the bypass bit high, every request takes 2 + L edges, whether or not the word was fetched before, and no read-ahead is started.
- R10: Any change of the latency, enable or bypass bits invalidates all entries.
- R11: A read-ahead starts only while no demand access is active. A request accepted during a read-ahead cancels it without waiting, and the cancelled word is not fetched later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_lat | input | 1 | Adds one wait cycle to each array access |
| cfg_pf_en | input | 1 | Instruction read-ahead enable |
| cfg_pr_en | input | 1 | Data read-ahead enable |
| cfg_bypass | input | 1 | Turns the buffer off for fixed timing |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted |
| req_addr | input | AW | Word address of the request |
| req_data | input | 1 | 1 = data read, 0 = instruction fetch |
| rsp_valid | output | 1 | Response word valid |
| rsp_ready | input | 1 | Response taken |
| rsp_rdata | output | DW | Response word |
| arr_en | output | 1 | Array access active |
| arr_addr | output | AW | Array word address |
| arr_rdata | input | DW | Array read word |

## Verification
The bench tries every combination of the latency, enable and bypass bits. For each one it measures the latency of a repeated read and of a read to the next word. A buffer that leaked hits into bypass mode would show a latency of one where 2 + L is expected. Read-ahead that ignored the stream kind would give a hit on the wrong stream's next word. A replacement order that is not least recently used, or partitions that are not separated, would keep the wrong word and turn an expected hit into a miss, or the reverse. The cancellation case sends a request during a read-ahead. A design that stalled would show extra latency, and one that retried the cancelled read would produce a hit on the next word.

// File: rtl/flash_rdbuf_pkg.sv
package flash_rdbuf_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DEM  = 2'd1,
    ST_RA   = 2'd2
  } fb_state_e;

  typedef struct packed {
    logic lat;
    logic pf;
    logic pr;
    logic byp;
  } fb_cfg_t;

endpackage

// File: rtl/flash_rdbuf_store.sv
module flash_rdbuf_store #(
  parameter int N_WORDS = 6,
  parameter int AW      = 12,
  parameter int DW      = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       inval,
  input  logic                       split,
  input  logic [AW-1:0]              lka_addr,
  output logic                       lka_hit,
  output logic [$clog2(N_WORDS)-1:0] lka_idx,
  output logic [DW-1:0]              lka_data,
  input  logic [AW-1:0]              lkb_addr,
  output logic                       lkb_hit,
  input  logic                       touch_en,
  input  logic [$clog2(N_WORDS)-1:0] touch_idx,
  input  logic                       fill_en,
  input  logic                       fill_str,
  input  logic [AW-1:0]              fill_tag,
  input  logic [DW-1:0]              fill_data
);
  localparam int IW   = $clog2(N_WORDS);
  localparam int HALF = N_WORDS / 2;

  logic [N_WORDS-1:0] vld;
  logic [AW-1:0]      tag [N_WORDS];
  logic [DW-1:0]      dat [N_WORDS];
  logic [IW-1:0]      age [N_WORDS];
  logic [N_WORDS-1:0] hv;
  logic [IW-1:0]      vic, upd_idx, gmax;
  logic               found, upd_en, upd_hi;

  // lookups: demand port A, read-ahead port B
  always_comb begin
    hv       = '0;
    lka_idx  = '0;
    lka_data = '0;
    lkb_hit  = 1'b0;
    for (int i = 0; i < N_WORDS; i++) begin
      hv[i] = vld[i] && (tag[i] == lka_addr);
      if (hv[i]) begin
        lka_idx  = IW'(i);
        lka_data = dat[i];
      end
      if (vld[i] && (tag[i] == lkb_addr)) lkb_hit = 1'b1;
    end
  end
  assign lka_hit = |hv;

  // victim: first free entry in the stream's group, else its oldest
  assign gmax = split ? IW'(HALF - 1) : IW'(N_WORDS - 1);
  always_comb begin
    found = 1'b0;
    vic   = '0;
    for (int i = 0; i < N_WORDS; i++)
      if (!found && !vld[i] && (!split || ((i >= HALF) == fill_str))) begin
        vic   = IW'(i);
        found = 1'b1;
      end
    for (int i = 0; i < N_WORDS; i++)
      if (!found && (!split || ((i >= HALF) == fill_str)) && age[i] == gmax)
        vic = IW'(i);
  end

  assign upd_en  = fill_en | touch_en;
  assign upd_idx = fill_en ? vic : touch_idx;
  assign upd_hi  = (upd_idx >= IW'(HALF));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_WORDS; i++) begin
        vld[i] <= 1'b0;
        age[i] <= IW'(i);
      end
    end else if (inval) begin
      for (int i = 0; i < N_WORDS; i++) begin
        vld[i] <= 1'b0;
        age[i] <= split ? IW'(i % HALF) : IW'(i);
      end
    end else if (upd_en) begin
      for (int i = 0; i < N_WORDS; i++) begin
        if (IW'(i) == upd_idx)
          age[i] <= '0;
        else if ((!split || ((i >= HALF) == upd_hi)) && (age[i] < age[upd_idx]))
          age[i] <= age[i] + 1'b1;
        if (fill_en && IW'(i) == vic) vld[i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en && !inval) begin
      tag[vic] <= fill_tag;
      dat[vic] <= fill_data;
    end
  end

  p_uniq_tag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hv));

endmodule

// File: rtl/flash_rdbuf_seq.sv
module flash_rdbuf_seq
  import flash_rdbuf_pkg::*;
#(
  parameter int N_WORDS = 6,
  parameter int AW      = 12,
  parameter int DW      = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  fb_cfg_t                    cfg,
  input  logic                       inval,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [AW-1:0]              req_addr,
  input  logic                       req_data,
  output logic                       rsp_valid,
  input  logic                       rsp_ready,
  output logic [DW-1:0]              rsp_rdata,
  output logic                       arr_en,
  output logic [AW-1:0]              arr_addr,
  input  logic [DW-1:0]              arr_rdata,
  input  logic                       lka_hit,
  input  logic [$clog2(N_WORDS)-1:0] lka_idx,
  input  logic [DW-1:0]              lka_data,
  output logic [AW-1:0]              lkb_addr,
  input  logic                       lkb_hit,
  output logic                       touch_en,
  output logic [$clog2(N_WORDS)-1:0] touch_idx,
  output logic                       fill_en,
  output logic                       fill_str,
  output logic [AW-1:0]              fill_tag,
  output logic [DW-1:0]              fill_data
);
  fb_state_e     st;
  logic          cnt, cur_str, use_buf, accept, ra_go, ra_str, byp;
  logic [AW-1:0] cur_addr, pf_addr, pr_addr;
  logic          pf_pend, pr_pend;

  assign byp       = cfg.byp;
  assign use_buf   = !cfg.byp;
  assign req_ready = (st != ST_DEM) && !rsp_valid;
  assign accept    = req_valid && req_ready;
  assign ra_str    = !pf_pend;
  assign lkb_addr  = pf_pend ? pf_addr : pr_addr;
  assign ra_go     = (st == ST_IDLE) && !accept && use_buf && !inval && (pf_pend || pr_pend);

  assign touch_en  = accept && use_buf && lka_hit;
  assign touch_idx = lka_idx;
  assign fill_en   = (st == ST_DEM && !cnt && use_buf) ||
                     (st == ST_RA && !cnt && !accept && !inval);
  assign fill_str  = cur_str;
  assign fill_tag  = cur_addr;
  assign fill_data = arr_rdata;
  assign arr_en    = (st == ST_DEM) || (st == ST_RA);
  assign arr_addr  = cur_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      cnt       <= 1'b0;
      cur_str   <= 1'b0;
      cur_addr  <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      pf_pend   <= 1'b0;
      pr_pend   <= 1'b0;
      pf_addr   <= '0;
      pr_addr   <= '0;
    end else begin
      if (rsp_valid && rsp_ready) rsp_valid <= 1'b0;
      case (st)
        ST_DEM: begin
          if (!cnt) begin
            rsp_valid <= 1'b1;
            rsp_rdata <= arr_rdata;
            st        <= ST_IDLE;
          end else cnt <= 1'b0;
        end
        default: begin
          if (accept) begin
            if (use_buf && lka_hit) begin
              rsp_valid <= 1'b1;
              rsp_rdata <= lka_data;
              st        <= ST_IDLE;
            end else begin
              st       <= ST_DEM;
              cnt      <= cfg.lat;
              cur_addr <= req_addr;
              cur_str  <= req_data;
            end
            if (use_buf && !req_data && cfg.pf) begin
              pf_addr <= req_addr + 1'b1;
              pf_pend <= 1'b1;
            end
            if (use_buf && req_data && cfg.pr) begin
              pr_addr <= req_addr + 1'b1;
              pr_pend <= 1'b1;
            end
          end else if (ra_go) begin
            if (!lkb_hit) begin
              st       <= ST_RA;
              cnt      <= cfg.lat;
              cur_addr <= lkb_addr;
              cur_str  <= ra_str;
            end
            if (pf_pend) pf_pend <= 1'b0;
            else         pr_pend <= 1'b0;
          end else if (st == ST_RA) begin
            if (inval || !cnt) st <= ST_IDLE;
            else cnt <= 1'b0;
          end
        end
      endcase
      if (inval) begin
        pf_pend <= 1'b0;
        pr_pend <= 1'b0;
      end
    end
  end

  p_rsp_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata));
  p_miss_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DEM) && !cnt |=> rsp_valid);
  p_byp_no_hit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    accept && byp |=> !rsp_valid);
  p_byp_no_ra_r9: assert property (@(posedge clk) disable iff (!rst_n)
    byp && $past(byp) |-> st != ST_RA);
  p_lat_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !(use_buf && lka_hit) && cfg.lat |=> st == ST_DEM && cnt);

endmodule

// File: rtl/flash_rdbuf.sv
module flash_rdbuf
  import flash_rdbuf_pkg::*;
#(
  parameter int N_WORDS = 6,
  parameter int AW      = 12,
  parameter int DW      = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_lat,
  input  logic          cfg_pf_en,
  input  logic          cfg_pr_en,
  input  logic          cfg_bypass,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic          req_data,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_rdata,
  output logic          arr_en,
  output logic [AW-1:0] arr_addr,
  input  logic [DW-1:0] arr_rdata
);
  localparam int IW = $clog2(N_WORDS);

  fb_cfg_t       cfg, cfg_q;
  logic          inval, split;
  logic          lka_hit, lkb_hit, touch_en, fill_en, fill_str;
  logic [IW-1:0] lka_idx, touch_idx;
  logic [DW-1:0] lka_data, fill_data;
  logic [AW-1:0] lkb_addr, fill_tag;

  assign cfg   = '{lat: cfg_lat, pf: cfg_pf_en, pr: cfg_pr_en, byp: cfg_bypass};
  assign inval = (cfg != cfg_q);
  assign split = cfg_pf_en & cfg_pr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg;
  end

  flash_rdbuf_store #(.N_WORDS(N_WORDS), .AW(AW), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n), .inval(inval), .split(split),
    .lka_addr(req_addr), .lka_hit(lka_hit), .lka_idx(lka_idx), .lka_data(lka_data),
    .lkb_addr(lkb_addr), .lkb_hit(lkb_hit),
    .touch_en(touch_en), .touch_idx(touch_idx),
    .fill_en(fill_en), .fill_str(fill_str), .fill_tag(fill_tag), .fill_data(fill_data)
  );

  flash_rdbuf_seq #(.N_WORDS(N_WORDS), .AW(AW), .DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .inval(inval),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .arr_en(arr_en), .arr_addr(arr_addr), .arr_rdata(arr_rdata),
    .lka_hit(lka_hit), .lka_idx(lka_idx), .lka_data(lka_data),
    .lkb_addr(lkb_addr), .lkb_hit(lkb_hit),
    .touch_en(touch_en), .touch_idx(touch_idx),
    .fill_en(fill_en), .fill_str(fill_str), .fill_tag(fill_tag), .fill_data(fill_data)
  );

endmodule

// File: tb/flash_rdbuf_bench.sv
`timescale 1ns/1ps
module flash_rdbuf_bench;
  localparam int AW = 12;
  localparam int DW = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_lat = 0, cfg_pf_en = 0, cfg_pr_en = 0, cfg_bypass = 0;
  logic req_valid = 0, req_data = 0, rsp_ready = 0;
  logic [AW-1:0] req_addr = '0;
  logic req_ready, rsp_valid, arr_en;
  logic [DW-1:0] rsp_rdata, arr_rdata;
  logic [AW-1:0] arr_addr;
  int vecs = 0, errs = 0;
  bit done = 0;

  always #4 clk = ~clk;

  function automatic logic [DW-1:0] fval(logic [AW-1:0] a);
    return (32'(a) * 32'd40503) ^ 32'h5A00_0000;
  endfunction
  assign arr_rdata = fval(arr_addr);

  flash_rdbuf u_flash_rdbuf (
    .clk(clk), .rst_n(rst_n), .cfg_lat(cfg_lat), .cfg_pf_en(cfg_pf_en),
    .cfg_pr_en(cfg_pr_en), .cfg_bypass(cfg_bypass),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .arr_en(arr_en), .arr_addr(arr_addr), .arr_rdata(arr_rdata)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_cfg(input logic l, input logic pf, input logic pr, input logic b);
    cfg_lat = l; cfg_pf_en = pf; cfg_pr_en = pr; cfg_bypass = b;
    repeat (3) @(negedge clk);
  endtask

  // called at a negedge; returns at a negedge
  task automatic rd(input logic [AW-1:0] a, input logic d, input int exp_lat,
                    input int idle, input string req);
    int n = 0;
    req_valid = 1; req_addr = a; req_data = d;
    while (!req_ready && n < 50) begin @(negedge clk); n++; end
    n = 1;
    @(negedge clk);
    req_valid = 0;
    while (!rsp_valid && n < 50) begin @(negedge clk); n++; end
    chk(n == exp_lat, {req, " latency"}, n, exp_lat);
    chk(rsp_rdata == fval(a), {req, " data"}, int'(rsp_rdata), int'(fval(a)));
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
    repeat (idle) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // reset state
    chk(rsp_valid == 0 && arr_en == 0, "R2 reset outputs", int'(rsp_valid), 0);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1, "R2 ready after reset", int'(req_ready), 1);

    // sweep: latency x read-ahead enables x bypass (R1 R2 R3 R5 R6 R9)
    for (int l = 0; l < 2; l++) begin
      for (int m = 0; m < 8; m++) begin
        logic [AW-1:0] a;
        logic d, pf, pr, b;
        int ml, nxt;
        pf = m[0]; pr = m[1]; b = m[2];
        d  = logic'((l + m) % 2);
        a  = AW'(16 * (l * 8 + m) + 32);
        ml = 2 + l;
        set_cfg(logic'(l), pf, pr, b);
        rd(a, d, ml, 6, "R2 R3 first read misses");
        rd(a, d, b ? ml : 1, 6, b ? "R9 bypass repeat" : "R1 repeat hits");
        nxt = (!b && ((!d && pf) || (d && pr))) ? 1 : ml;
        rd(a + 1'b1, d, nxt, 6, b ? "R9 no read-ahead" : "R5 R6 next word");
      end
    end

    // R5 with lat 1: data stream must not prefetch; R6 instruction must not pre-read
    set_cfg(1, 1, 0, 0);
    rd(12'h400, 1, 3, 6, "R5 data miss");
    rd(12'h401, 1, 3, 6, "R5 data starts no prefetch");
    set_cfg(0, 0, 1, 0);
    rd(12'h410, 0, 2, 6, "R6 instr miss");
    rd(12'h411, 0, 2, 6, "R6 instr starts no pre-read");

    // R4 capacity and R8 LRU, no read-ahead
    set_cfg(0, 0, 0, 0);
    for (int i = 0; i < 6; i++) rd(AW'(12'h100 + i), 1, 2, 2, "R4 fill");
    for (int i = 0; i < 6; i++) rd(AW'(12'h100 + i), 1, 1, 2, "R4 six words held");
    rd(12'h106, 0, 2, 2, "R8 seventh word misses");
    rd(12'h101, 0, 1, 2, "R8 recent word kept");
    rd(12'h100, 0, 2, 2, "R8 oldest word evicted");
    rd(12'h102, 0, 2, 2, "R8 next oldest evicted");

    // R7 split partitions
    set_cfg(0, 1, 1, 0);
    rd(12'h500, 1, 2, 6, "R7 data fill");
    rd(12'h180, 0, 2, 6, "R7 instr fill");
    rd(12'h200, 0, 2, 6, "R7 instr fill");
    rd(12'h500, 1, 1, 6, "R7 data kept in own half");
    rd(12'h180, 0, 2, 6, "R7 instr half of three evicted");
    // R7 shared: same pattern with one enable
    set_cfg(0, 1, 0, 0);
    rd(12'h500, 1, 2, 6, "R7 shared data fill");
    rd(12'h180, 0, 2, 6, "R7 shared instr fill");
    rd(12'h200, 0, 2, 6, "R7 shared instr fill");
    rd(12'h180, 0, 1, 6, "R7 shared six entries");

    // R10 configuration change invalidates
    set_cfg(0, 0, 0, 0);
    rd(12'h300, 0, 2, 4, "R10 fill");
    rd(12'h300, 0, 1, 4, "R10 hit before change");
    set_cfg(0, 0, 0, 1);
    set_cfg(0, 0, 0, 0);
    rd(12'h300, 0, 2, 4, "R10 miss after change");

    // R11 demand request cancels read-ahead in flight
    set_cfg(1, 1, 0, 0);
    rd(12'h380, 0, 3, 0, "R11 instr miss");
    rd(12'h3C0, 1, 3, 6, "R11 demand during read-ahead");
    rd(12'h381, 0, 3, 6, "R11 cancelled word not fetched");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule